// File: doc/BRIEF.md
# Chainable Down-Counting Timer Slice

This block is an 8-bit timer slice that counts down. It holds a count register, a period register and a compare register. A single slice works as a timer on its own. Identical slices can also be wired into a wider timer through two cascade paths that run in opposite directions. The carry path runs from less significant slices to more significant ones, and tells each slice that every slice below it has reached zero. The terminal path runs from more significant slices to less significant ones, and tells each slice that every slice above it has reached zero. A slice counts down only while its carry input is high. The whole chain reloads from the period registers only when every slice is at zero, so the chained slices behave as one wide down-counter.

A terminal-count pulse and an interrupt follow the cycle in which the whole chain is at zero. A mode input chooses how long the pulse lasts: a full clock cycle, or only the low half of the clock. The current count can be copied into the compare register in two ways. One is a rising edge on an asynchronous data input, which is first synchronized. The other is a one-cycle read strobe that marks a processor read of the count. The magnitude comparator chain is a separate block, and register decoding happens outside this block.

Top module: `tmr_slice`

## Requirements
- R1: While `rst` is high at a rising edge, the count, period and compare registers are cleared to 00h. From then on `tc`, `co`, `tco` and `irq` read low until the block is enabled.
- R2: While `en` is low, `tc`, `co`, `tco` and `irq` are all low in the same cycle. The count holds its value unless the period is written. The compare register holds its value unless it is written. Capture is suppressed.
- R3: At a rising edge with `en` and `ci` high, the count decrements by one, except under the reload condition of R4. A count of 00h with `tci` low wraps to FFh.
- R4: At a rising edge with `en`, `ci` and `tci` high and the count at 00h, the count loads the period value that was held before that edge.
- R5: `co` is high exactly when `en` and `ci` are high and the count is 00h. `tco` is high exactly when `en` and `tci` are high and the count is 00h.
- R6: If the reload condition of R4 holds at an edge, then `irq` and `tc` are high for the whole following cycle in full-width mode (`half_tc` = 0), provided `en` stays high.
- R7: With `half_tc` = 1, `tc` is low whenever `clk` is high. With a period of 00h in a standalone or fully chained timer, `tc` therefore follows the inverse of `clk`.
- R8: A rising edge on `cap_in` passes through a two-flop synchronizer. On the third rising `clk` edge after `cap_in` rises, the compare register loads the count value held just before that edge.
- R9: A one-cycle `cnt_rd` pulse while enabled loads the compare register with the count value held before the next edge.
- R10: Writing the period (`per_we`) while disabled also loads the count with `wr_data`. Writing the period while enabled leaves the count to continue its sequence.
- R11: When `cmp_we` and a capture occur in the same cycle, the compare register takes `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Slice enable; when low, all outputs are gated low |
| half_tc | input | 1 | 1 = terminal pulse only in the low phase of the clock, 0 = full cycle |
| ci | input | 1 | Carry in: all lower slices are at zero (tie high for the lowest slice) |
| tci | input | 1 | Terminal in: all higher slices are at zero (tie high for the highest slice) |
| cap_in | input | 1 | Asynchronous capture input, acts on its rising edge |
| cnt_rd | input | 1 | One-cycle strobe marking a read of the count |
| per_we | input | 1 | Period write strobe |
| cmp_we | input | 1 | Compare register write strobe |
| wr_data | input | 8 | Write data for period and compare registers |
| cnt_q | output | 8 | Current count |
| cmp_q | output | 8 | Compare / capture register |
| tc | output | 1 | Terminal count pulse |
| co | output | 1 | Carry out to the next more significant slice |
| tco | output | 1 | Terminal out to the next less significant slice |
| irq | output | 1 | Interrupt, one full cycle after the terminal count |

## Verification
The assertions check the following on every cycle: output gating while disabled, the decrement and reload steps of the count, the meaning of `co`, the interrupt that follows a terminal count, and the loads of the compare register from a read strobe or a write. The bench joins two slices into a 16-bit timer and compares it each cycle against a 16-bit behavioural counter. This is how it shows the wrap of the lower slice from 00h to FFh, the reload of the whole chain only at all-zero, the three-edge latency of the synchronized capture, and the half-cycle pulse shape. The half-cycle shape can only be seen by sampling both phases of the clock.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int TMR_W    = 8;
    localparam int SYNC_LEN = 2;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_DEC,
        ACT_RELOAD,
        ACT_LOAD
    } cnt_act_e;

    typedef struct packed {
        logic zero;
        logic co;
        logic tco;
        logic term;
    } chain_t;

    function automatic cnt_act_e pick_act(input logic en, input logic ci,
                                          input logic tci, input logic zero,
                                          input logic per_we);
        if (!en)
            return per_we ? ACT_LOAD : ACT_HOLD;
        else if (!ci)
            return ACT_HOLD;
        else if (tci && zero)
            return ACT_RELOAD;
        return ACT_DEC;
    endfunction

    function automatic chain_t make_chain(input logic en, input logic ci,
                                          input logic tci, input logic zero);
        chain_t c;
        c.zero = zero;
        c.co   = en & ci & zero;
        c.tco  = en & tci & zero;
        c.term = en & ci & tci & zero;
        return c;
    endfunction

endpackage

// File: rtl/tmr_cap_sync.sv
`timescale 1ns/1ps
module tmr_cap_sync #(
    parameter int STAGES = tmr_pkg::SYNC_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic din,
    output logic rise
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh;

    generate
        for (genvar i = 0; i < LEN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst || clr) sh[i] <= 1'b0;
                    else            sh[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst || clr) sh[i] <= 1'b0;
                    else            sh[i] <= sh[i-1];
                end
            end
        end
    endgenerate

    assign rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core #(
    parameter int W = tmr_pkg::TMR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ci,
    input  logic              tci,
    input  logic              per_we,
    input  logic              cmp_we,
    input  logic [W-1:0]      wr_data,
    input  logic              cap_ld,
    output logic [W-1:0]      cnt_q,
    output logic [W-1:0]      per_q,
    output logic [W-1:0]      cmp_q,
    output tmr_pkg::chain_t   chain
);
    import tmr_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    logic     zero;
    cnt_act_e act;

    assign zero  = (cnt_q == '0);
    assign act   = pick_act(en, ci, tci, zero, per_we);
    assign chain = make_chain(en, ci, tci, zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (act)
                ACT_LOAD:   cnt_q <= wr_data;
                ACT_RELOAD: cnt_q <= per_q;
                ACT_DEC:    cnt_q <= cnt_q - ONE;
                default:    cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         per_q <= '0;
        else if (per_we) per_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= '0;
        else if (cmp_we) cmp_q <= wr_data;
        else if (cap_ld) cmp_q <= cnt_q;
    end

endmodule

// File: rtl/tmr_tc_out.sv
`timescale 1ns/1ps
module tmr_tc_out (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic half_tc,
    input  logic term,
    output logic tc,
    output logic irq
);
    logic tc_q;

    always_ff @(posedge clk) begin
        if (rst || !en) tc_q <= 1'b0;
        else            tc_q <= term;
    end

    assign irq = en & tc_q;
    assign tc  = en & tc_q & (half_tc ? ~clk : 1'b1);

endmodule

// File: rtl/tmr_slice.sv
`timescale 1ns/1ps
module tmr_slice #(
    parameter int W = tmr_pkg::TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         half_tc,
    input  logic         ci,
    input  logic         tci,
    input  logic         cap_in,
    input  logic         cnt_rd,
    input  logic         per_we,
    input  logic         cmp_we,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cmp_q,
    output logic         tc,
    output logic         co,
    output logic         tco,
    output logic         irq
);
    import tmr_pkg::*;

    logic         cap_rise;
    logic         cap_ld;
    logic [W-1:0] per_q;
    chain_t       chain;

    tmr_cap_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .clr  (~en),
        .din  (cap_in),
        .rise (cap_rise)
    );

    assign cap_ld = en & (cap_rise | cnt_rd);

    tmr_count_core #(.W(W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .ci      (ci),
        .tci     (tci),
        .per_we  (per_we),
        .cmp_we  (cmp_we),
        .wr_data (wr_data),
        .cap_ld  (cap_ld),
        .cnt_q   (cnt_q),
        .per_q   (per_q),
        .cmp_q   (cmp_q),
        .chain   (chain)
    );

    tmr_tc_out u_tc (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .half_tc (half_tc),
        .term    (chain.term),
        .tc      (tc),
        .irq     (irq)
    );

    assign co  = chain.co;
    assign tco = chain.tco;

endmodule

// File: rtl/tmr_slice_chk.sv
`timescale 1ns/1ps
module tmr_slice_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         ci,
    input logic         tci,
    input logic         cnt_rd,
    input logic         per_we,
    input logic         cmp_we,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] per_q,
    input logic [W-1:0] cmp_q,
    input logic         tc,
    input logic         co,
    input logic         tco,
    input logic         irq
);
    // R2
    off_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !(tc || co || tco || irq));

    // R2
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !per_we) |=> cnt_q == $past(cnt_q));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (en && ci && !(tci && cnt_q == '0)) |=> cnt_q == $past(cnt_q) - W'(1));

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (en && ci && tci && cnt_q == '0) |=> cnt_q == $past(per_q));

    // R5
    carry_mean_chk: assert property (@(posedge clk) disable iff (rst)
        co |-> (ci && en && cnt_q == '0));

    // R5
    term_mean_chk: assert property (@(posedge clk) disable iff (rst)
        tco |-> (tci && en && cnt_q == '0));

    // R6
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (en && ci && tci && cnt_q == '0) |=> (!en || irq));

    // R9
    read_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt_rd && !cmp_we) |=> cmp_q == $past(cnt_q));

    // R11
    cmp_write_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> cmp_q == $past(wr_data));

endmodule

bind tmr_slice tmr_slice_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .ci      (ci),
    .tci     (tci),
    .cnt_rd  (cnt_rd),
    .per_we  (per_we),
    .cmp_we  (cmp_we),
    .wr_data (wr_data),
    .cnt_q   (cnt_q),
    .per_q   (per_q),
    .cmp_q   (cmp_q),
    .tc      (tc),
    .co      (co),
    .tco     (tco),
    .irq     (irq)
);

// File: tb/tmr_slice_bench.sv
`timescale 1ns/1ps
module tmr_slice_bench;
    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, en, half_tc, cap_in, cnt_rd, per_we, cmp_we;
    logic [W-1:0] wd_lo, wd_hi;
    logic [W-1:0] cnt_lo, cnt_hi, cmp_lo, cmp_hi;
    logic tc_lo, tc_hi, co_lo, co_hi, tco_lo, tco_hi, irq_lo, irq_hi;

    tmr_slice u_tmr_slice (
        .clk(clk), .rst(rst), .en(en), .half_tc(half_tc),
        .ci(1'b1), .tci(tco_hi), .cap_in(cap_in), .cnt_rd(cnt_rd),
        .per_we(per_we), .cmp_we(cmp_we), .wr_data(wd_lo),
        .cnt_q(cnt_lo), .cmp_q(cmp_lo), .tc(tc_lo), .co(co_lo),
        .tco(tco_lo), .irq(irq_lo)
    );

    tmr_slice u_tmr_slice_hi (
        .clk(clk), .rst(rst), .en(en), .half_tc(half_tc),
        .ci(co_lo), .tci(1'b1), .cap_in(cap_in), .cnt_rd(cnt_rd),
        .per_we(per_we), .cmp_we(cmp_we), .wr_data(wd_hi),
        .cnt_q(cnt_hi), .cmp_q(cmp_hi), .tc(tc_hi), .co(co_hi),
        .tco(tco_hi), .irq(irq_hi)
    );

    int errs = 0;
    int checks = 0;

    // behavioural 16-bit reference
    int m_cnt = 0, m_per = 0, m_cmp = 0;
    bit m_tc = 0;
    bit reloaded = 0;
    bit [2:0] hist = '0;

    task automatic chk(input string req, input string nm, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
        end
    endtask

    task automatic model_next();
        int nc;
        bit rise, cap;
        if (rst) begin
            m_cnt = 0; m_per = 0; m_cmp = 0; m_tc = 0; hist = '0; reloaded = 0;
            return;
        end
        nc = m_cnt;
        reloaded = 0;
        rise = hist[1] && !hist[2];
        if (en) begin
            if (m_cnt == 0) begin nc = m_per; reloaded = 1; end
            else nc = m_cnt - 1;
        end else if (per_we) begin
            nc = {wd_hi, wd_lo};
        end
        m_tc = en && (m_cnt == 0);
        cap = en && (rise || cnt_rd);
        if (cmp_we) m_cmp = {wd_hi, wd_lo};
        else if (cap) m_cmp = m_cnt;
        if (per_we) m_per = {wd_hi, wd_lo};
        hist = en ? {hist[1:0], cap_in} : 3'b000;
        m_cnt = nc;
    endtask

    task automatic check_all();
        int ex_tc;
        ex_tc = (en && m_tc) ? 1 : 0;
        chk(rst ? "R1" : (reloaded ? "R4" : "R3"), "count", {cnt_hi, cnt_lo}, m_cnt);
        chk(rst ? "R1" : "R8", "compare", {cmp_hi, cmp_lo}, m_cmp);
        chk("R6", "tc_lo", tc_lo, ex_tc);
        chk("R6", "tc_hi", tc_hi, ex_tc);
        chk("R6", "irq_lo", irq_lo, ex_tc);
        chk("R6", "irq_hi", irq_hi, ex_tc);
        chk("R5", "co_lo", co_lo, (en && (m_cnt & 255) == 0) ? 1 : 0);
        chk("R5", "co_hi", co_hi, (en && m_cnt == 0) ? 1 : 0);
        chk("R5", "tco_hi", tco_hi, (en && (m_cnt >> 8) == 0) ? 1 : 0);
        chk("R5", "tco_lo", tco_lo, (en && m_cnt == 0) ? 1 : 0);
    endtask

    task automatic step();
        model_next();
        @(posedge clk);
        #2;
        if (half_tc) chk("R7", "tc_high_phase", tc_lo, 0);
        @(negedge clk);
        #1;
        check_all();
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst = 1; en = 0; half_tc = 0; cap_in = 0; cnt_rd = 0;
        per_we = 0; cmp_we = 0; wd_lo = '0; wd_hi = '0;
        @(negedge clk);
        step(); step();
        // R1 reset state
        chk("R1", "cnt_after_reset", {cnt_hi, cnt_lo}, 0);
        rst = 0;
        // R10 period write while disabled loads the count
        per_we = 1; wd_hi = 8'h01; wd_lo = 8'h03;
        step();
        per_we = 0;
        chk("R10", "count_loaded", {cnt_hi, cnt_lo}, 16'h0103);
        // R2 disabled: hold
        repeat (3) step();
        chk("R2", "count_held", {cnt_hi, cnt_lo}, 16'h0103);
        // R3 R4 R5 R6: run through wrap and full reload
        en = 1;
        repeat (300) step();
        // R10 period write while enabled leaves count alone
        per_we = 1; wd_hi = 8'h00; wd_lo = 8'h30;
        step();
        per_we = 0;
        repeat (5) step();
        // R8 synchronized edge capture
        cap_in = 1;
        repeat (4) step();
        cap_in = 0;
        step();
        // R9 read strobe capture
        cnt_rd = 1;
        step();
        cnt_rd = 0;
        chk("R9", "read_capture", {cmp_hi, cmp_lo}, m_cmp);
        step();
        // R11 write wins over capture
        cnt_rd = 1; cmp_we = 1; wd_hi = 8'h5A; wd_lo = 8'hA5;
        step();
        cnt_rd = 0; cmp_we = 0;
        chk("R11", "write_priority", {cmp_hi, cmp_lo}, 16'h5AA5);
        // R2 disable mid-count
        repeat (3) step();
        en = 0;
        #1;
        chk("R2", "co_gated", co_lo | co_hi | tco_lo | tco_hi | tc_lo | irq_lo, 0);
        repeat (5) step();
        chk("R2", "compare_held", {cmp_hi, cmp_lo}, 16'h5AA5);
        en = 1;
        repeat (60) step();
        // R7 half-cycle pulse
        half_tc = 1;
        repeat (60) step();
        en = 0; per_we = 1; wd_hi = 8'h00; wd_lo = 8'h00;
        step();
        per_we = 0; en = 1;
        repeat (3) step();
        chk("R7", "tc_low_phase", tc_lo, 1);
        repeat (10) step();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule